// File: doc/BRIEF.md
# Conversion Result Buffer with Byte Readout

This block sits between the sequencing logic of a multichannel converter and its serial read path. It stores voltage results in a 16-deep circular queue and keeps one temperature result in a dedicated slot outside that queue. Each stored result is a 16-bit entry. A voltage entry carries its 10-bit code and two sub-bits behind four zero bits. A temperature entry carries a 12-bit two's-complement value, in eighths of a degree, behind four zero bits.

The serial shifter is outside this block. It asks for data one byte at a time. While chip select is low, the block shows the current byte on `rd_byte_o`. When the shifter finishes with that byte, it pulses `byte_done_i` and reports on `bits_i` how many bits it actually shifted out. A count of eight is a full byte. A smaller count is a byte cut short by chip select rising. The read position then moves on according to the partial-read rules below.

A pending temperature result is always served before any voltage entry. When the queue is full and a new voltage result arrives, the oldest voltage result is dropped. The clear input discards every stored result.

Top module: `conv_result_fifo`

## Requirements
- R1: Voltage entries are read out in the order they were written. `count_o` rises by one for each voltage write that is made while the queue is not full and no entry is popped in the same cycle.
- R2: A voltage write to a full queue (16 entries) drops the oldest voltage entry. `count_o` stays at 16 and `full_o` stays high, and the next entry read is the second-oldest one.
- R3: A voltage entry is read as two bytes. The first is {4'b0000, code[9:6]} and the second is {code[5:0], sub[1:0]}.
- R4: A temperature entry is read as two bytes. The first is {4'b0000, t[11:8]} and the second is t[7:0].
- R5: While a temperature result is stored, its two bytes are delivered before any voltage entry.
- R6: A temperature write replaces an unread earlier temperature result, and only one temperature entry is ever delivered.
- R7: When nothing is stored (`empty_o` high), `rd_byte_o` is zero, and a byte strobe changes nothing.
- R8: A voltage write and a completed second-byte read of a voltage entry in the same cycle on a full queue leave `count_o` at 16.
- R9: If the first byte of an entry ends after k shifted bits (0<k<8), the next byte shown is bits [15-k:8-k] of that entry. When that byte ends, the rest of the entry is dropped and the next entry starts at its first byte.
- R10: If the first byte is read fully and the second byte ends after fewer than 8 bits, the rest of that entry is dropped, and the next entry is read intact from its first byte.
- R11: A cycle with `clear_i` high empties the queue and the temperature slot. On the next cycle `empty_o` is 1, `count_o` is 0 and the read position is back at a first byte.
- R12: While `cs_n_i` is high, `rd_byte_o` is zero and byte strobes are ignored. A strobe with `bits_i` = 0 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Discard all stored results |
| wr_volt_i | input | 1 | Write strobe for a voltage result |
| volt_code_i | input | 10 | Voltage code |
| volt_sub_i | input | 2 | Voltage sub-bits |
| wr_temp_i | input | 1 | Write strobe for a temperature result |
| temp_code_i | input | 12 | Temperature code, two's complement |
| cs_n_i | input | 1 | Read framing, active low |
| byte_done_i | input | 1 | Byte-advance strobe from the shifter |
| bits_i | input | 4 | Bits shifted in the byte that ended (0 to 8) |
| rd_byte_o | output | 8 | Current byte |
| full_o | output | 1 | Voltage queue holds 16 entries |
| empty_o | output | 1 | No voltage and no temperature result stored |
| count_o | output | 5 | Number of stored voltage entries |

## Verification
The hardest case to reach is a full queue that takes a new voltage result in the same cycle as the second byte of its head entry completes. This cycle must neither overwrite nor lose an entry. The stimulus gets there by writing seventeen results, reading the first byte of the head, and then raising the write strobe together with a full-byte strobe. The partial-read paths also need exact cycle placement: the shifted byte after a cut-short first byte is checked against a shifted copy of the known entry, and the byte that follows it must be the next entry's first byte.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;
  typedef enum logic {SRC_VOLT = 1'b0, SRC_TEMP = 1'b1} src_e;
endpackage

// File: rtl/rfifo_queue.sv
module rfifo_queue #(
  parameter int DEPTH = 16,
  parameter int EW    = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [EW-1:0]                wdata_i,
  output logic [EW-1:0]                head_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         ovw_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_pop;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty_o;
  // full and nobody reading: the oldest slot is reused
  assign ovw_o   = push_i & full_o & ~do_pop;
  assign head_o  = mem[rp_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i && !clear_i) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i)          wp_q <= nxt(wp_q);
      if (do_pop || ovw_o) rp_q <= nxt(rp_q);
      if (push_i && !do_pop && !full_o) cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !push_i)       cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rfifo_byte_sel.sv
module rfifo_byte_sel #(
  parameter int BW  = 8,
  parameter int SHW = 4
) (
  input  logic [2*BW-1:0] entry_i,
  input  logic [SHW-1:0]  sh_i,
  output logic [BW-1:0]   byte_o
);
  logic [2*BW-1:0] shifted;
  assign shifted = entry_i << sh_i;
  assign byte_o  = shifted[2*BW-1 -: BW];
endmodule

// File: rtl/rfifo_rd_ctrl.sv
module rfifo_rd_ctrl
  import rfifo_pkg::*;
#(
  parameter int BW  = 8,
  parameter int BCW = 4,
  parameter int SHW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           cs_n_i,
  input  logic           byte_done_i,
  input  logic [BCW-1:0] bits_i,
  input  logic           temp_vld_i,
  input  logic           q_empty_i,
  input  logic           ovw_i,
  output src_e           src_o,
  output logic           active_o,
  output logic [SHW-1:0] sh_o,
  output logic           pop_q_o,
  output logic           pop_t_o
);
  logic           phase_q;   // 0: at first byte, 1: inside entry
  src_e           src_q;
  logic [SHW-1:0] sh_q;
  logic           adv;

  assign src_o    = phase_q ? src_q : (temp_vld_i ? SRC_TEMP : SRC_VOLT);
  assign active_o = phase_q | temp_vld_i | ~q_empty_i;
  assign adv      = byte_done_i & ~cs_n_i & (bits_i != '0) & active_o;
  assign pop_q_o  = adv & phase_q & (src_q == SRC_VOLT);
  assign pop_t_o  = adv & phase_q & (src_q == SRC_TEMP);
  assign sh_o     = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      src_q   <= SRC_VOLT;
      sh_q    <= '0;
    end else if (clear_i) begin
      phase_q <= 1'b0;
      src_q   <= SRC_VOLT;
      sh_q    <= '0;
    end else if (adv && !phase_q) begin
      // head overwritten in the same cycle: restart on the new head
      if (!(ovw_i && src_o == SRC_VOLT)) begin
        phase_q <= 1'b1;
        src_q   <= src_o;
        sh_q    <= (bits_i >= BCW'(BW)) ? SHW'(BW) : SHW'(bits_i);
      end
    end else if (adv) begin
      phase_q <= 1'b0;
      sh_q    <= '0;
    end else if (ovw_i && phase_q && src_q == SRC_VOLT) begin
      phase_q <= 1'b0;
      sh_q    <= '0;
    end
  end
endmodule

// File: rtl/conv_result_fifo.sv
module conv_result_fifo
  import rfifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int VW    = 10,
  parameter int SW    = 2,
  parameter int TW    = 12,
  parameter int BW    = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clear_i,
  input  logic                       wr_volt_i,
  input  logic [VW-1:0]              volt_code_i,
  input  logic [SW-1:0]              volt_sub_i,
  input  logic                       wr_temp_i,
  input  logic [TW-1:0]              temp_code_i,
  input  logic                       cs_n_i,
  input  logic                       byte_done_i,
  input  logic [$clog2(BW+1)-1:0]    bits_i,
  output logic [BW-1:0]              rd_byte_o,
  output logic                       full_o,
  output logic                       empty_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int EW   = 2 * BW;
  localparam int BCW  = $clog2(BW+1);
  localparam int SHW  = $clog2(BW+1);
  localparam int VPAD = EW - VW - SW;
  localparam int TPAD = EW - TW;

  logic [EW-1:0]  volt_entry, temp_entry, q_head, cur_entry;
  logic [TW-1:0]  temp_q;
  logic           temp_vld_q;
  logic           q_empty, ovw, pop_q, pop_t, active;
  logic [SHW-1:0] sh;
  logic [BW-1:0]  sel_byte;
  src_e           src;

  assign volt_entry = {{VPAD{1'b0}}, volt_code_i, volt_sub_i};
  assign temp_entry = {{TPAD{1'b0}}, temp_q};

  rfifo_queue #(.DEPTH(DEPTH), .EW(EW)) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .push_i  (wr_volt_i),
    .pop_i   (pop_q),
    .wdata_i (volt_entry),
    .head_o  (q_head),
    .count_o (count_o),
    .full_o  (full_o),
    .empty_o (q_empty),
    .ovw_o   (ovw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      temp_q     <= '0;
      temp_vld_q <= 1'b0;
    end else if (clear_i) begin
      temp_vld_q <= 1'b0;
    end else if (wr_temp_i) begin
      temp_q     <= temp_code_i;
      temp_vld_q <= 1'b1;
    end else if (pop_t) begin
      temp_vld_q <= 1'b0;
    end
  end

  rfifo_rd_ctrl #(.BW(BW), .BCW(BCW), .SHW(SHW)) u_rd_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .cs_n_i      (cs_n_i),
    .byte_done_i (byte_done_i),
    .bits_i      (bits_i),
    .temp_vld_i  (temp_vld_q),
    .q_empty_i   (q_empty),
    .ovw_i       (ovw),
    .src_o       (src),
    .active_o    (active),
    .sh_o        (sh),
    .pop_q_o     (pop_q),
    .pop_t_o     (pop_t)
  );

  assign cur_entry = (src == SRC_TEMP) ? temp_entry : q_head;

  rfifo_byte_sel #(.BW(BW), .SHW(SHW)) u_byte_sel (
    .entry_i (cur_entry),
    .sh_i    (sh),
    .byte_o  (sel_byte)
  );

  assign rd_byte_o = (!cs_n_i && active) ? sel_byte : '0;
  assign empty_o   = q_empty & ~temp_vld_q;
endmodule

// File: rtl/rfifo_checker.sv
module rfifo_checker #(
  parameter int DEPTH = 16,
  parameter int VW    = 10,
  parameter int SW    = 2,
  parameter int TW    = 12,
  parameter int BW    = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       clear_i,
  input logic                       wr_volt_i,
  input logic [VW-1:0]              volt_code_i,
  input logic [SW-1:0]              volt_sub_i,
  input logic                       wr_temp_i,
  input logic [TW-1:0]              temp_code_i,
  input logic                       cs_n_i,
  input logic                       byte_done_i,
  input logic [$clog2(BW+1)-1:0]    bits_i,
  input logic [BW-1:0]              rd_byte_o,
  input logic                       full_o,
  input logic                       empty_o,
  input logic [$clog2(DEPTH+1)-1:0] count_o
);
  localparam int CW = $clog2(DEPTH+1);

  AST_COUNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH)); // R1

  AST_PUSH_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_volt_i && !full_o && !clear_i && !byte_done_i) |=> (count_o == $past(count_o) + 1'b1)); // R1

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_volt_i && !clear_i) |=> full_o); // R2

  AST_FULL_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && wr_volt_i && !clear_i) |=> (count_o == CW'(DEPTH))); // R8

  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_byte_o == '0)); // R7

  AST_CLEAR_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (empty_o && count_o == '0)); // R11

  AST_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> (rd_byte_o == '0)); // R12
endmodule

bind conv_result_fifo rfifo_checker #(
  .DEPTH(DEPTH), .VW(VW), .SW(SW), .TW(TW), .BW(BW)
) u_chk (.*);

// File: tb/conv_result_fifo_test.sv
module conv_result_fifo_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0, wr_volt = 1'b0, wr_temp = 1'b0;
  logic [9:0] vcode = '0;
  logic [1:0] vsub = '0;
  logic [11:0] tcode = '0;
  logic       cs_n = 1'b1, bdone = 1'b0;
  logic [3:0] bits = '0;
  logic [7:0] rbyte;
  logic       full, empty;
  logic [4:0] count;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  conv_result_fifo uut (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear),
    .wr_volt_i(wr_volt), .volt_code_i(vcode), .volt_sub_i(vsub),
    .wr_temp_i(wr_temp), .temp_code_i(tcode),
    .cs_n_i(cs_n), .byte_done_i(bdone), .bits_i(bits),
    .rd_byte_o(rbyte), .full_o(full), .empty_o(empty), .count_o(count)
  );

  // {code[9:0], sub[1:0]}
  localparam logic [11:0] VEC [6] = '{12'h3FF, 12'h000, 12'hA5E, 12'h5A1, 12'h812, 12'h1C3};

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wv(input logic [11:0] v);
    @(negedge clk);
    wr_volt = 1'b1; vcode = v[11:2]; vsub = v[1:0];
    @(negedge clk);
    wr_volt = 1'b0;
  endtask

  task automatic wt(input logic [11:0] t);
    @(negedge clk);
    wr_temp = 1'b1; tcode = t;
    @(negedge clk);
    wr_temp = 1'b0;
  endtask

  // check the shown byte, then let k bits be consumed
  task automatic rd(input logic [7:0] exp, input int k, input string tag);
    @(negedge clk);
    chk(rbyte, exp, tag);
    bdone = 1'b1; bits = 4'(k);
    @(negedge clk);
    bdone = 1'b0; bits = '0;
  endtask

  task automatic do_clear;
    @(negedge clk);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
  endtask

  function automatic logic [15:0] ve(input logic [11:0] v);
    return {4'h0, v};
  endfunction

  function automatic logic [7:0] sh_byte(input logic [15:0] e, input int k);
    logic [15:0] s;
    s = e << k;
    return s[15:8];
  endfunction

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk(empty, 1, "R11 reset empty");
    chk(count, 0, "R1 reset count");
    chk(full, 0, "R2 reset full");
    cs_n = 1'b0;
    @(negedge clk);
    chk(rbyte, 0, "R7 empty byte");
    rd(8'h00, 8, "R7 strobe on empty");
    chk(empty, 1, "R7 still empty");

    // table: write all, read all in order
    foreach (VEC[i]) wv(VEC[i]);
    @(negedge clk);
    chk(count, 6, "R1 count after table");
    foreach (VEC[i]) begin
      rd(ve(VEC[i])[15:8], 8, "R3 high byte");
      rd(ve(VEC[i])[7:0], 8, "R3 low byte");
    end
    chk(empty, 1, "R1 drained");

    // temperature priority
    wv(12'h123); wv(12'h456); wt(12'hF9C);
    rd({4'h0, 4'hF}, 8, "R4 temp high");
    rd(8'h9C, 8, "R5 temp first low");
    rd(ve(12'h123)[15:8], 8, "R5 volt after temp");
    rd(ve(12'h123)[7:0], 8, "R5 volt low");
    rd(ve(12'h456)[15:8], 8, "R5 second volt");
    rd(ve(12'h456)[7:0], 8, "R5 second volt low");

    // temperature replacement
    wt(12'h111); wt(12'h7E2); wv(12'hABC);
    rd(8'h07, 8, "R6 new temp high");
    rd(8'hE2, 8, "R6 new temp low");
    rd(ve(12'hABC)[15:8], 8, "R6 no second temp");
    rd(ve(12'hABC)[7:0], 8, "R6 volt low");

    // overwrite when full
    for (int i = 0; i < 17; i++) wv(12'(i * 37 + 5));
    @(negedge clk);
    chk(count, 16, "R2 count at full");
    chk(full, 1, "R2 full flag");
    rd(ve(12'(1 * 37 + 5))[15:8], 8, "R2 oldest dropped");
    // write and second-byte read in the same cycle on a full queue
    @(negedge clk);
    chk(rbyte, ve(12'(1 * 37 + 5))[7:0], "R8 low byte");
    bdone = 1'b1; bits = 4'd8; wr_volt = 1'b1; vcode = 10'h3AA; vsub = 2'b01;
    @(negedge clk);
    bdone = 1'b0; bits = '0; wr_volt = 1'b0;
    chk(count, 16, "R8 count unchanged");
    chk(rbyte, ve(12'(2 * 37 + 5))[15:8], "R8 next entry");

    // clear
    do_clear;
    chk(empty, 1, "R11 clear empty");
    chk(count, 0, "R11 clear count");
    chk(rbyte, 0, "R11 clear byte");

    // partial first byte
    wv(12'hA96); wv(12'h5C3); wv(12'h2F0);
    rd(ve(12'hA96)[15:8], 3, "R9 first byte");
    rd(sh_byte(ve(12'hA96), 3), 8, "R9 shifted byte");
    // partial second byte
    rd(ve(12'h5C3)[15:8], 8, "R9 next entry after drop");
    rd(ve(12'h5C3)[7:0], 5, "R10 partial low");
    rd(ve(12'h2F0)[15:8], 8, "R10 next entry intact");
    rd(ve(12'h2F0)[7:0], 8, "R10 next entry low");

    // deselected strobes and zero-bit strobes ignored
    wv(12'h9D4);
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
    chk(rbyte, 0, "R12 idle byte");
    bdone = 1'b1; bits = 4'd8;
    @(negedge clk);
    bdone = 1'b0; bits = '0;
    cs_n = 1'b0;
    rd(ve(12'h9D4)[15:8], 0, "R12 cs-high strobe ignored");
    rd(ve(12'h9D4)[15:8], 8, "R12 zero-bit strobe ignored");
    rd(ve(12'h9D4)[7:0], 8, "R12 low byte");
    chk(empty, 1, "R12 drained");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule